// File: doc/BRIEF.md
# SPI Host Command Engine

This engine sits on the host side of an SPI link to a peripheral that is driven through short command frames. The host logic presents an opcode, a 24-bit address, write data, a transfer size and a few protection options, then pulses `start`. The engine selects the byte layout that belongs to the opcode and sends the frame through a byte-wide SPI master port. If CRC7 protection is on, it appends a trailer byte. It then sends 0x00 filler on MOSI while it collects the reply.

Every reply must first echo the opcode and then return a zero status byte. For the two read opcodes that return a register value, the engine also skips a limited number of filler bytes until it finds a data-start tag. It then captures four data bytes and, when requested, checks a CRC16 that follows them. The result is reported as a one-cycle `done` pulse, with `err` raised in the same cycle when any check fails.

Top module: `spi_cmd_engine`

## Requirements
- R1: Opcode 0xCA (single read) sends 0xCA then address bits 23:0 as three bytes, most significant first. Opcode 0xC9 (single write) sends 0xC9, the same three address bytes, then `wdata` as four bytes, most significant first.
- R2: Opcode 0xC4 (internal read) sends 0xC4, then address bits 15:8 with bit 7 forced to 1 when `clockless` is high, then address bits 7:0, then a 0x00 pad byte. Opcode 0xC3 (internal write) sends the same two address bytes followed directly by the four `wdata` bytes, with no pad.
- R3: Opcodes 0xC1 and 0xC2 send the opcode, three address bytes and `xfer_size` bits 15:0 as two bytes. Opcodes 0xC7 and 0xC8 send the opcode, three address bytes and `xfer_size` bits 23:0 as three bytes. Opcodes 0xC5, 0xC6 and 0xCF send the opcode and three address bytes. All fields go most significant byte first.
- R4: When `crc7_en` is high, one extra byte follows the frame. It carries the CRC7 (polynomial x^7+x^3+1, register seeded to all ones, bits taken MSB first) of all preceding frame bytes in bits 7:1, with bit 0 at 0.
- R5: While the engine collects reply bytes, it drives 0x00 on `spi_tx`.
- R6: If the first reply byte differs from the opcode, the engine ends at that byte with `err` = 1.
- R7: If the second reply byte is not 0x00, the engine ends at that byte with `err` = 1. For opcodes without a data phase, a zero status ends the command with `err` = 0.
- R8: For opcodes 0xCA and 0xC4, the engine reads up to 8 bytes after the status byte and looks for one whose upper nibble is 0xF. If all 8 are examined without a match, it ends with `err` = 1.
- R9: The four bytes after the tag are placed on `rdata`, first byte in bits 31:24.
- R10: When `crc16_en` is high and `clockless` is low, two more bytes are read (high byte first). They are compared with the CRC-CCITT (polynomial 0x1021, seed 0xFFFF) of the four data bytes, and a mismatch sets `err` = 1. Otherwise no CRC bytes are read.
- R11: An opcode outside the supported set yields `done` with `err` = 1 one cycle after `start`, and no SPI byte is requested.
- R12: `busy` is high from the cycle after an accepted `start` until the command ends. `done` is a single-cycle pulse with `busy` low. `start` while busy has no effect. `spi_req` stays high with `spi_tx` unchanged until `spi_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a command (accepted when idle) |
| opcode | input | 8 | Command opcode |
| addr | input | 24 | Target address |
| wdata | input | 32 | Write data for 0xC9 and 0xC3 |
| xfer_size | input | 24 | Size field for DMA opcodes |
| clockless | input | 1 | Clockless internal access (forces address bit and skips CRC16) |
| crc7_en | input | 1 | Append the CRC7 trailer |
| crc16_en | input | 1 | Expect and check CRC16 after read data |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Failure flag, valid with `done` |
| rdata | output | 32 | Captured read data |
| spi_req | output | 1 | Byte transfer request to the SPI master |
| spi_tx | output | 8 | Byte to shift out on MOSI |
| spi_ack | input | 1 | Byte transfer complete |
| spi_rx | input | 8 | Byte shifted in on MISO, valid with `spi_ack` |

## Verification
The tag search can find its tag in the same cycle that the search window runs out: the eighth filler position is both the last one allowed and the position where the tag arrives. The bench places the tag at position eight and expects success with the correct data. It then places non-tag bytes in all eight positions and expects a failure after exactly fourteen transferred bytes. A second collision is a new `start` that arrives while a command is still in flight. The bench uses a slow SPI responder and confirms that the logged MOSI frame belongs only to the first opcode and that exactly one `done` pulse appears.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  localparam int ADDR_W      = 24;
  localparam int WDATA_W     = 32;
  localparam int SIZE_W      = 24;
  localparam int FRAME_BYTES = 8;
  localparam int FRAME_W     = FRAME_BYTES * 8;
  localparam int FLEN_W      = $clog2(FRAME_BYTES) + 1;
  localparam int DATA_BYTES  = WDATA_W / 8;

  localparam logic [7:0] OP_DMA_WR  = 8'hC1;
  localparam logic [7:0] OP_DMA_RD  = 8'hC2;
  localparam logic [7:0] OP_INT_WR  = 8'hC3;
  localparam logic [7:0] OP_INT_RD  = 8'hC4;
  localparam logic [7:0] OP_TERM    = 8'hC5;
  localparam logic [7:0] OP_REPEAT  = 8'hC6;
  localparam logic [7:0] OP_XDMA_WR = 8'hC7;
  localparam logic [7:0] OP_XDMA_RD = 8'hC8;
  localparam logic [7:0] OP_SGL_WR  = 8'hC9;
  localparam logic [7:0] OP_SGL_RD  = 8'hCA;
  localparam logic [7:0] OP_RESET   = 8'hCF;

  localparam logic [3:0] TAG_NIBBLE = 4'hF;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CMD,
    ST_CRC7,
    ST_ECHO,
    ST_STAT,
    ST_SEEK,
    ST_DATA,
    ST_CHK_HI,
    ST_CHK_LO
  } eng_state_t;

endpackage

// File: rtl/spi_cmd_frame.sv
module spi_cmd_frame
  import spi_cmd_pkg::*;
(
  input  logic [7:0]         opcode,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [WDATA_W-1:0] wdata,
  input  logic [SIZE_W-1:0]  xfer_size,
  input  logic               clockless,
  output logic [FRAME_W-1:0] frame,
  output logic [FLEN_W-1:0]  flen,
  output logic               known,
  output logic               has_rdata
);

  logic [7:0] int_hi;

  always_comb begin
    int_hi = {addr[15] | clockless, addr[14:8]};
  end

  always_comb begin
    frame     = '0;
    flen      = '0;
    known     = 1'b1;
    has_rdata = 1'b0;
    case (opcode)
      OP_SGL_RD: begin
        frame     = {opcode, addr, 32'h0};
        flen      = FLEN_W'(4);
        has_rdata = 1'b1;
      end
      OP_INT_RD: begin
        frame     = {opcode, int_hi, addr[7:0], 8'h00, 32'h0};
        flen      = FLEN_W'(4);
        has_rdata = 1'b1;
      end
      OP_SGL_WR: begin
        frame = {opcode, addr, wdata};
        flen  = FLEN_W'(8);
      end
      OP_INT_WR: begin
        frame = {opcode, int_hi, addr[7:0], wdata, 8'h00};
        flen  = FLEN_W'(7);
      end
      OP_DMA_WR, OP_DMA_RD: begin
        frame = {opcode, addr, xfer_size[15:0], 16'h0};
        flen  = FLEN_W'(6);
      end
      OP_XDMA_WR, OP_XDMA_RD: begin
        frame = {opcode, addr, xfer_size, 8'h00};
        flen  = FLEN_W'(7);
      end
      OP_TERM, OP_REPEAT, OP_RESET: begin
        frame = {opcode, addr, 32'h0};
        flen  = FLEN_W'(4);
      end
      default: begin
        known = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/spi_crc_acc.sv
module spi_crc_acc #(
  parameter int           W    = 7,
  parameter logic [W-1:0] POLY = 7'h09,
  parameter logic [W-1:0] SEED = 7'h7F
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [7:0]   din,
  output logic [W-1:0] crc
);

  logic [W-1:0] crc_q;
  logic [W-1:0] crc_d;

  always_comb begin
    logic fb;
    crc_d = crc_q;
    for (int i = 7; i >= 0; i--) begin
      fb    = crc_d[W-1] ^ din[i];
      crc_d = {crc_d[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= SEED;
    end else if (clr) begin
      crc_q <= SEED;
    end else if (en) begin
      crc_q <= crc_d;
    end
  end

  assign crc = crc_q;

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int FILLER_MAX = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [7:0]         opcode,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [WDATA_W-1:0] wdata,
  input  logic [SIZE_W-1:0]  xfer_size,
  input  logic               clockless,
  input  logic               crc7_en,
  input  logic               crc16_en,
  output logic               busy,
  output logic               done,
  output logic               err,
  output logic [WDATA_W-1:0] rdata,
  output logic               spi_req,
  output logic [7:0]         spi_tx,
  input  logic               spi_ack,
  input  logic [7:0]         spi_rx
);

  localparam int SEEK_W = $clog2(FILLER_MAX) + 1;
  localparam int CNT_W  = (SEEK_W > FLEN_W) ? SEEK_W : FLEN_W;
  localparam logic [CNT_W-1:0] SEEK_LAST = CNT_W'(FILLER_MAX - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_BYTES - 1);

  // frame builder outputs
  logic [FRAME_W-1:0] b_frame;
  logic [FLEN_W-1:0]  b_flen;
  logic               b_known;
  logic               b_rd;

  spi_cmd_frame frame_i (
    .opcode    (opcode),
    .addr      (addr),
    .wdata     (wdata),
    .xfer_size (xfer_size),
    .clockless (clockless),
    .frame     (b_frame),
    .flen      (b_flen),
    .known     (b_known),
    .has_rdata (b_rd)
  );

  // state
  eng_state_t         state_q, state_d;
  logic [FRAME_W-1:0] frame_q, frame_d;
  logic [FLEN_W-1:0]  flen_q, flen_d;
  logic [7:0]         op_q, op_d;
  logic               rd_q, rd_d;
  logic               c7_q, c7_d;
  logic               chk_q, chk_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [WDATA_W-1:0] rdata_q, rdata_d;
  logic [7:0]         hi_q, hi_d;
  logic               done_q, done_d;
  logic               err_q, err_d;
  logic               launch;

  logic [6:0]  crc7_val;
  logic [15:0] crc16_val;
  logic        crc7_step;
  logic        crc16_step;

  assign crc7_step  = spi_ack && (state_q == ST_CMD);
  assign crc16_step = spi_ack && (state_q == ST_DATA);

  spi_crc_acc #(.W(7), .POLY(7'h09), .SEED(7'h7F)) crc7_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (launch),
    .en    (crc7_step),
    .din   (spi_tx),
    .crc   (crc7_val)
  );

  spi_crc_acc #(.W(16), .POLY(16'h1021), .SEED(16'hFFFF)) crc16_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (launch),
    .en    (crc16_step),
    .din   (spi_rx),
    .crc   (crc16_val)
  );

  // MOSI byte select
  always_comb begin
    case (state_q)
      ST_CMD:  spi_tx = frame_q[FRAME_W-1 -: 8];
      ST_CRC7: spi_tx = {crc7_val, 1'b0};
      default: spi_tx = 8'h00;
    endcase
  end

  assign spi_req = (state_q != ST_IDLE);
  assign busy    = (state_q != ST_IDLE);
  assign done    = done_q;
  assign err     = err_q;
  assign rdata   = rdata_q;

  // next state
  always_comb begin
    state_d = state_q;
    frame_d = frame_q;
    flen_d  = flen_q;
    op_d    = op_q;
    rd_d    = rd_q;
    c7_d    = c7_q;
    chk_d   = chk_q;
    cnt_d   = cnt_q;
    rdata_d = rdata_q;
    hi_d    = hi_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    launch  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (b_known) begin
            state_d = ST_CMD;
            launch  = 1'b1;
            frame_d = b_frame;
            flen_d  = b_flen;
            op_d    = opcode;
            rd_d    = b_rd;
            c7_d    = crc7_en;
            chk_d   = crc16_en & ~clockless;
            cnt_d   = '0;
          end else begin
            done_d = 1'b1;
            err_d  = 1'b1;
          end
        end
      end
      ST_CMD: begin
        if (spi_ack) begin
          frame_d = frame_q << 8;
          if (cnt_q == CNT_W'(flen_q - FLEN_W'(1))) begin
            cnt_d   = '0;
            state_d = c7_q ? ST_CRC7 : ST_ECHO;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
      end
      ST_CRC7: begin
        if (spi_ack) begin
          state_d = ST_ECHO;
        end
      end
      ST_ECHO: begin
        if (spi_ack) begin
          if (spi_rx != op_q) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
            err_d   = 1'b1;
          end else begin
            state_d = ST_STAT;
          end
        end
      end
      ST_STAT: begin
        if (spi_ack) begin
          if (spi_rx != 8'h00) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
            err_d   = 1'b1;
          end else if (rd_q) begin
            state_d = ST_SEEK;
            cnt_d   = '0;
          end else begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end
        end
      end
      ST_SEEK: begin
        if (spi_ack) begin
          if (spi_rx[7:4] == TAG_NIBBLE) begin
            state_d = ST_DATA;
            cnt_d   = '0;
          end else if (cnt_q == SEEK_LAST) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
            err_d   = 1'b1;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
      end
      ST_DATA: begin
        if (spi_ack) begin
          rdata_d = {rdata_q[WDATA_W-9:0], spi_rx};
          if (cnt_q == DATA_LAST) begin
            if (chk_q) begin
              state_d = ST_CHK_HI;
            end else begin
              state_d = ST_IDLE;
              done_d  = 1'b1;
            end
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
      end
      ST_CHK_HI: begin
        if (spi_ack) begin
          hi_d    = spi_rx;
          state_d = ST_CHK_LO;
        end
      end
      ST_CHK_LO: begin
        if (spi_ack) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          err_d   = ({hi_q, spi_rx} != crc16_val);
        end
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      frame_q <= '0;
      flen_q  <= '0;
      op_q    <= '0;
      rd_q    <= 1'b0;
      c7_q    <= 1'b0;
      chk_q   <= 1'b0;
      cnt_q   <= '0;
      rdata_q <= '0;
      hi_q    <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      frame_q <= frame_d;
      flen_q  <= flen_d;
      op_q    <= op_d;
      rd_q    <= rd_d;
      c7_q    <= c7_d;
      chk_q   <= chk_d;
      cnt_q   <= cnt_d;
      rdata_q <= rdata_d;
      hi_q    <= hi_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk #(
  parameter int FILLER_MAX = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic       spi_req,
  input logic       spi_ack,
  input logic [7:0] spi_tx,
  input logic [7:0] op_lat,
  input logic       in_seek
);

  logic [15:0] seek_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seek_n <= '0;
    end else if (!in_seek) begin
      seek_n <= '0;
    end else if (spi_ack) begin
      seek_n <= seek_n + 16'd1;
    end
  end

  // R12: request and byte held until acknowledged
  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_req && !spi_ack) |=> (spi_req && $stable(spi_tx)));

  // R12: start while busy leaves the latched opcode alone
  a_r12_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(op_lat));

  // R12: completion only when idle and not requesting bytes
  a_r12_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !spi_req));

  // R6: error flag only with done
  a_r6_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  // R8: search window never exceeds its bound
  a_r8_seek_bound: assert property (@(posedge clk) disable iff (!rst_n)
    in_seek |-> (seek_n < 16'(FILLER_MAX)));

endmodule

bind spi_cmd_engine spi_cmd_engine_chk #(.FILLER_MAX(FILLER_MAX)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .err     (err),
  .spi_req (spi_req),
  .spi_ack (spi_ack),
  .spi_tx  (spi_tx),
  .op_lat  (op_q),
  .in_seek (state_q == spi_cmd_pkg::ST_SEEK)
);

// File: tb/spi_cmd_engine_tb_top.sv
module spi_cmd_engine_tb_top;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [7:0]  opcode;
  logic [23:0] addr;
  logic [31:0] wdata;
  logic [23:0] xsize;
  logic        cl, c7, c16;
  logic        busy, done, err;
  logic [31:0] rdata;
  logic        spi_req;
  logic [7:0]  spi_tx;
  logic        spi_ack;
  logic [7:0]  spi_rx;

  int checks;
  int errors;
  bit finished;

  logic [7:0] rx_stream [64];
  logic [7:0] tx_log [64];
  int nb;
  int lat;
  int dones;
  logic [7:0] exp_f [16];
  int exp_n;
  logic got_err;
  logic [31:0] got_rdata;

  spi_cmd_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .addr(addr),
    .wdata(wdata), .xfer_size(xsize), .clockless(cl), .crc7_en(c7),
    .crc16_en(c16), .busy(busy), .done(done), .err(err), .rdata(rdata),
    .spi_req(spi_req), .spi_tx(spi_tx), .spi_ack(spi_ack), .spi_rx(spi_rx)
  );

  initial begin
    clk = 1'b0;
    forever #4 clk = ~clk;
  end

  // SPI byte responder
  initial begin
    int gap;
    gap = 0;
    spi_ack = 1'b0;
    spi_rx = 8'h00;
    forever begin
      @(negedge clk);
      if (spi_req && gap >= lat && nb < 64) begin
        spi_ack = 1'b1;
        spi_rx = rx_stream[nb];
        tx_log[nb] = spi_tx;
        nb++;
        gap = 0;
      end else begin
        spi_ack = 1'b0;
        if (spi_req) gap++;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (done === 1'b1) dones++;
    end
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_crc7(input int n);
    logic [7:0] r;
    r = 8'hFE;
    for (int k = 0; k < n; k++) begin
      for (int i = 7; i >= 0; i--) begin
        logic top;
        top = r[7] ^ exp_f[k][i];
        r = r << 1;
        if (top) r = r ^ 8'h12;
      end
    end
    return r & 8'hFE;
  endfunction

  function automatic logic [15:0] ref_crc16(input logic [31:0] d);
    logic [15:0] c;
    c = 16'hFFFF;
    for (int k = 3; k >= 0; k--) begin
      c = c ^ {d[k*8 +: 8], 8'h00};
      for (int i = 0; i < 8; i++) begin
        c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
      end
    end
    return c;
  endfunction

  task automatic build_exp(input logic [7:0] op, input logic [23:0] a, input logic [31:0] d,
                           input logic [23:0] s, input logic clk_less, input logic with_c7);
    exp_f[0] = op;
    case (op)
      8'hC4: begin
        exp_f[1] = a[15:8] | (clk_less ? 8'h80 : 8'h00);
        exp_f[2] = a[7:0]; exp_f[3] = 8'h00; exp_n = 4;
      end
      8'hC3: begin
        exp_f[1] = a[15:8] | (clk_less ? 8'h80 : 8'h00);
        exp_f[2] = a[7:0];
        exp_f[3] = d[31:24]; exp_f[4] = d[23:16]; exp_f[5] = d[15:8]; exp_f[6] = d[7:0];
        exp_n = 7;
      end
      default: begin
        exp_f[1] = a[23:16]; exp_f[2] = a[15:8]; exp_f[3] = a[7:0];
        exp_n = 4;
        if (op == 8'hC9) begin
          exp_f[4] = d[31:24]; exp_f[5] = d[23:16]; exp_f[6] = d[15:8]; exp_f[7] = d[7:0];
          exp_n = 8;
        end else if (op == 8'hC1 || op == 8'hC2) begin
          exp_f[4] = s[15:8]; exp_f[5] = s[7:0]; exp_n = 6;
        end else if (op == 8'hC7 || op == 8'hC8) begin
          exp_f[4] = s[23:16]; exp_f[5] = s[15:8]; exp_f[6] = s[7:0]; exp_n = 7;
        end
      end
    endcase
    if (with_c7) begin
      exp_f[exp_n] = ref_crc7(exp_n);
      exp_n++;
    end
  endtask

  task automatic prep();
    for (int i = 0; i < 64; i++) begin
      rx_stream[i] = 8'h5A;
      tx_log[i] = 8'h00;
    end
    nb = 0;
    dones = 0;
  endtask

  task automatic put_data(input int base, input logic [31:0] d);
    rx_stream[base]   = d[31:24];
    rx_stream[base+1] = d[23:16];
    rx_stream[base+2] = d[15:8];
    rx_stream[base+3] = d[7:0];
  endtask

  task automatic wait_done(input string req);
    int t;
    t = 0;
    while (done !== 1'b1 && t < 3000) begin
      @(negedge clk);
      t++;
    end
    got_err = err;
    got_rdata = rdata;
    if (t >= 3000) chk(req, "done timeout", 64'd1, 64'd0);
  endtask

  task automatic run(input string req, input logic [7:0] op, input logic [23:0] a, input logic [31:0] d,
                     input logic [23:0] s, input logic k_cl, input logic k_c7, input logic k_c16);
    @(negedge clk);
    opcode = op; addr = a; wdata = d; xsize = s; cl = k_cl; c7 = k_c7; c16 = k_c16;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(req);
  endtask

  task automatic check_frame(input string req);
    int bad;
    bad = -1;
    for (int i = 0; i < exp_n; i++) begin
      if (tx_log[i] !== exp_f[i] && bad < 0) bad = i;
    end
    if (bad >= 0) chk(req, "frame byte", 64'(tx_log[bad]), 64'(exp_f[bad]));
    else chk(req, "frame", 64'd0, 64'd0);
  endtask

  task automatic check_dummy(input string req, input int from, input int upto);
    int bad;
    bad = -1;
    for (int i = from; i < upto; i++) begin
      if (tx_log[i] !== 8'h00 && bad < 0) bad = i;
    end
    if (bad >= 0) chk(req, "dummy MOSI", 64'(tx_log[bad]), 64'd0);
    else chk(req, "dummy MOSI", 64'd0, 64'd0);
  endtask

  task automatic t_reset();
    chk("R12", "busy after reset", 64'(busy), 64'd0);
    chk("R12", "spi_req after reset", 64'(spi_req), 64'd0);
    chk("R12", "done/err after reset", 64'({done, err}), 64'd0);
  endtask

  task automatic t_single_read();
    prep(); lat = 0;
    build_exp(8'hCA, 24'h123456, 32'h0, 24'h0, 1'b0, 1'b0);
    rx_stream[4] = 8'hCA; rx_stream[5] = 8'h00;
    rx_stream[6] = 8'h00; rx_stream[7] = 8'h00; rx_stream[8] = 8'hF3;
    put_data(9, 32'hDEADBEEF);
    run("R1", 8'hCA, 24'h123456, 32'h0, 24'h0, 1'b0, 1'b0, 1'b0);
    check_frame("R1");
    check_dummy("R5", 4, 13);
    chk("R9", "rdata", 64'(got_rdata), 64'hDEADBEEF);
    chk("R8", "err", 64'(got_err), 64'd0);
    chk("R8", "byte count", 64'(nb), 64'd13);
  endtask

  task automatic t_single_write_crc7();
    prep(); lat = 1;
    build_exp(8'hC9, 24'hA1B2C3, 32'h11223344, 24'h0, 1'b0, 1'b1);
    rx_stream[9] = 8'hC9; rx_stream[10] = 8'h00;
    run("R4", 8'hC9, 24'hA1B2C3, 32'h11223344, 24'h0, 1'b0, 1'b1, 1'b0);
    check_frame("R4");
    chk("R7", "write err", 64'(got_err), 64'd0);
    chk("R7", "write byte count", 64'(nb), 64'd11);
  endtask

  task automatic t_internal_read_clockless();
    prep(); lat = 0;
    build_exp(8'hC4, 24'h001234, 32'h0, 24'h0, 1'b1, 1'b1);
    rx_stream[5] = 8'hC4; rx_stream[6] = 8'h00; rx_stream[7] = 8'hF0;
    put_data(8, 32'hCAFEF00D);
    run("R2", 8'hC4, 24'h001234, 32'h0, 24'h0, 1'b1, 1'b1, 1'b1);
    check_frame("R2");
    chk("R10", "clockless skips CRC16 count", 64'(nb), 64'd12);
    chk("R9", "clockless rdata", 64'(got_rdata), 64'hCAFEF00D);
    chk("R10", "clockless err", 64'(got_err), 64'd0);
  endtask

  task automatic t_internal_read_crc16(input logic corrupt);
    logic [15:0] c;
    prep(); lat = 0;
    build_exp(8'hC4, 24'h0000A8, 32'h0, 24'h0, 1'b0, 1'b0);
    rx_stream[4] = 8'hC4; rx_stream[5] = 8'h00; rx_stream[6] = 8'h00; rx_stream[7] = 8'hFF;
    put_data(8, 32'h01234567);
    c = ref_crc16(32'h01234567);
    if (corrupt) c = c ^ 16'h0100;
    rx_stream[12] = c[15:8]; rx_stream[13] = c[7:0];
    run("R10", 8'hC4, 24'h0000A8, 32'h0, 24'h0, 1'b0, 1'b0, 1'b1);
    if (!corrupt) check_frame("R2");
    chk("R10", "crc16 byte count", 64'(nb), 64'd14);
    chk("R10", corrupt ? "bad crc16 err" : "good crc16 err", 64'(got_err), 64'(corrupt));
  endtask

  task automatic t_internal_write();
    prep(); lat = 0;
    build_exp(8'hC3, 24'h0000AB, 32'h01020304, 24'h0, 1'b0, 1'b0);
    rx_stream[7] = 8'hC3; rx_stream[8] = 8'h00;
    run("R2", 8'hC3, 24'h0000AB, 32'h01020304, 24'h0, 1'b0, 1'b0, 1'b0);
    check_frame("R2");
    chk("R2", "internal write count", 64'(nb), 64'd9);
  endtask

  task automatic t_dma(input logic [7:0] op, input logic [23:0] s);
    prep(); lat = 0;
    build_exp(op, 24'h0A0B0C, 32'h0, s, 1'b0, 1'b0);
    rx_stream[exp_n] = op; rx_stream[exp_n+1] = 8'h00;
    run("R3", op, 24'h0A0B0C, 32'h0, s, 1'b0, 1'b0, 1'b0);
    check_frame("R3");
    chk("R3", "dma byte count", 64'(nb), 64'(exp_n + 2));
    chk("R3", "dma err", 64'(got_err), 64'd0);
  endtask

  task automatic t_echo_bad();
    prep(); lat = 0;
    rx_stream[4] = 8'hC0; rx_stream[5] = 8'h00;
    run("R6", 8'hCA, 24'h000010, 32'h0, 24'h0, 1'b0, 1'b0, 1'b0);
    chk("R6", "echo mismatch err", 64'(got_err), 64'd1);
    chk("R6", "stops at echo", 64'(nb), 64'd5);
  endtask

  task automatic t_status_bad();
    prep(); lat = 0;
    rx_stream[8] = 8'hC9; rx_stream[9] = 8'h02;
    run("R7", 8'hC9, 24'h000010, 32'h55, 24'h0, 1'b0, 1'b0, 1'b0);
    chk("R7", "status err", 64'(got_err), 64'd1);
    chk("R7", "stops at status", 64'(nb), 64'd10);
  endtask

  task automatic t_seek_edge();
    prep(); lat = 0;
    rx_stream[4] = 8'hCA; rx_stream[5] = 8'h00;
    for (int i = 6; i < 13; i++) rx_stream[i] = 8'h0E;
    rx_stream[13] = 8'hF3;
    put_data(14, 32'h89ABCDEF);
    run("R8", 8'hCA, 24'h000020, 32'h0, 24'h0, 1'b0, 1'b0, 1'b0);
    chk("R8", "tag at last slot err", 64'(got_err), 64'd0);
    chk("R9", "tag at last slot rdata", 64'(got_rdata), 64'h89ABCDEF);
    chk("R8", "tag at last slot count", 64'(nb), 64'd18);
    prep();
    rx_stream[4] = 8'hCA; rx_stream[5] = 8'h00;
    for (int i = 6; i < 14; i++) rx_stream[i] = 8'hE0;
    rx_stream[14] = 8'hF3;
    run("R8", 8'hCA, 24'h000020, 32'h0, 24'h0, 1'b0, 1'b0, 1'b0);
    chk("R8", "no tag err", 64'(got_err), 64'd1);
    chk("R8", "no tag count", 64'(nb), 64'd14);
  endtask

  task automatic t_bad_opcode();
    prep(); lat = 0;
    run("R11", 8'h55, 24'h0, 32'h0, 24'h0, 1'b0, 1'b0, 1'b0);
    chk("R11", "unknown opcode err", 64'(got_err), 64'd1);
    repeat (3) @(negedge clk);
    chk("R11", "no SPI bytes", 64'(nb), 64'd0);
  endtask

  task automatic t_busy_start();
    prep(); lat = 3;
    build_exp(8'hC9, 24'h314159, 32'h26535897, 24'h0, 1'b0, 1'b0);
    rx_stream[8] = 8'hC9; rx_stream[9] = 8'h00;
    @(negedge clk);
    opcode = 8'hC9; addr = 24'h314159; wdata = 32'h26535897; cl = 0; c7 = 0; c16 = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    opcode = 8'hCA; addr = 24'h000001;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done("R12");
    repeat (10) @(negedge clk);
    check_frame("R12");
    chk("R12", "busy start count", 64'(nb), 64'd10);
    chk("R12", "single done pulse", 64'(dones), 64'd1);
    chk("R12", "idle after", 64'({busy, spi_req}), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R12 watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; finished = 0;
    lat = 0; nb = 0; dones = 0;
    for (int i = 0; i < 64; i++) begin
      rx_stream[i] = 8'h5A;
      tx_log[i] = 8'h00;
    end
    rst_n = 1'b0; start = 1'b0; opcode = 8'h00; addr = '0; wdata = '0; xsize = '0;
    cl = 0; c7 = 0; c16 = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single_read();
    t_single_write_crc7();
    t_internal_read_clockless();
    t_internal_read_crc16(1'b0);
    t_internal_read_crc16(1'b1);
    t_internal_write();
    t_dma(8'hC1, 24'h000200);
    t_dma(8'hC8, 24'h012345);
    t_dma(8'hCF, 24'h0);
    t_echo_bad();
    t_status_bad();
    t_seek_edge();
    t_bad_opcode();
    t_busy_start();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule